// File: doc/BRIEF.md
# Exception Vector Address Generator

This block works out the instruction fetch address that a processor core jumps to when it takes an exception or an interrupt. The core gives it the class of the event, the interrupt vector number, the current boot-mode and interrupt-vector-select control bits, and the encoded vector spacing. On a one-cycle take strobe the block registers the entry address and raises a valid pulse with it.

The block also holds the programmable exception base register. Software may write this register only while the core is in boot mode. A write made outside boot mode has no effect and is flagged. In boot mode every vector lands in a fixed uncached boot region. Outside boot mode the vectors are placed relative to the programmed base. When the interrupt-vector-select bit is set, each interrupt also gets its own slot, found from its number times the spacing.

Top module: `exc_vector_gen`

## Requirements
- R1: After reset, `base_o` reads 0x80000000, and `addr_valid_o` and `wr_reject_o` are both 0.
- R2: Event class code 0 (reset, soft reset or NMI) gives the entry address 0xBFC00000, whatever the values of `bev_i`, `iv_i`, `vec_num_i` and `spacing_i`.
- R3: When `bev_i` is 1, every other class uses the base 0xBFC00000 plus its fixed offset, and no computed offset is added.
- R4: When `bev_i` is 0, every class other than code 0 uses the value of the base register as its base.
- R5: Class code 2 (general) uses offset 0x180, and class code 3 behaves the same. Class code 1 (interrupt) uses offset 0x200 when `iv_i` is 1 and offset 0x180 when `iv_i` is 0.
- R6: An interrupt taken with `bev_i`=0 and `iv_i`=1 adds `vec_num_i` × spacing. The spacing is 32 × `spacing_i` bytes when `spacing_i` is one of 0, 1, 2, 4, 8 or 16. For example, base 0x9FC01000 with vector 8 and code 1 gives 0x9FC01300.
- R7: Any other `spacing_i` value is treated as 0 bytes, and `cfg_bad_o` is 1 for as long as that value is applied. For a legal value `cfg_bad_o` is 0.
- R8: A write (`base_wr_i`=1) with `bev_i`=1 loads `base_wdata_i[29:12]` into bits 29:12 of the base register at the clock edge. `base_o[31:30]` always read 2'b10 and `base_o[11:0]` always read zero.
- R9: A write with `bev_i`=0 leaves `base_o` unchanged. In the cycle after it, `wr_reject_o` is 1 for one cycle. An accepted write leaves `wr_reject_o` at 0.
- R10: `addr_valid_o` is 1 for exactly the cycle after each edge at which `take_i` is 1. In that cycle `addr_o` holds the address computed from the inputs and the base register as they stood at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Exception-take strobe |
| class_i | input | 2 | Event class: 0 fixed-entry, 1 interrupt, 2 or 3 general |
| vec_num_i | input | 6 | Interrupt vector number |
| bev_i | input | 1 | Boot-mode bit |
| iv_i | input | 1 | Interrupt-vector-select bit |
| spacing_i | input | 5 | Encoded vector spacing |
| base_wr_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 32 | Base register write data |
| base_o | output | 32 | Current base register value |
| addr_o | output | 32 | Registered entry address |
| addr_valid_o | output | 1 | One-cycle valid pulse for `addr_o` |
| wr_reject_o | output | 1 | Pulse that flags an ignored base write |
| cfg_bad_o | output | 1 | Illegal spacing encoding applied |

## Verification
The assertions assume that every input has settled before the rising edge and is never unknown. They also assume that a base write and a take may fall in the same cycle, in which case the take sees the old base value. The stimulus changes inputs only on the falling edge and holds them steady across the rising edge. It drives every class code, including the spare code 3. It walks every vector number against every spacing code, legal and illegal, under all four combinations of boot mode and vector select. It repeats that sweep with two base values, one of them with every writable bit set.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    CLS_FIXED = 2'd0,
    CLS_INTR  = 2'd1,
    CLS_GEN   = 2'd2,
    CLS_GEN2  = 2'd3
  } exc_cls_e;

  localparam logic [ADDR_W-1:0] BOOT_BASE = 32'hBFC0_0000;
  localparam logic [ADDR_W-1:0] OFS_GEN   = 32'h0000_0180;
  localparam logic [ADDR_W-1:0] OFS_INTR  = 32'h0000_0200;
  localparam int SLOT_SHIFT = 5;  // one spacing step = 32 bytes
  localparam int BASE_HI = 29;
  localparam int BASE_LO = 12;
  localparam int BASE_W  = BASE_HI - BASE_LO + 1;
  localparam logic [1:0] BASE_TOP = 2'b10;

  // Fixed offset chosen by class and vector-select bit
  function automatic logic [ADDR_W-1:0] fixed_offset(input exc_cls_e cls, input logic iv);
    return (cls == CLS_INTR && iv) ? OFS_INTR : OFS_GEN;
  endfunction

  // Register image as seen at the port
  function automatic logic [ADDR_W-1:0] base_image(input logic [BASE_W-1:0] q);
    return {BASE_TOP, q, {BASE_LO{1'b0}}};
  endfunction
endpackage

// File: rtl/exc_spacing_dec.sv
module exc_spacing_dec
  import exc_vec_pkg::*;
#(
  parameter int SPC_W = 5
) (
  input  logic [SPC_W-1:0]            code_i,
  output logic [SPC_W+SLOT_SHIFT-1:0] bytes_o,
  output logic                        bad_o
);
  logic legal;

  // legal when the code is zero or a single power of two
  assign legal   = $onehot0(code_i);
  assign bad_o   = !legal;
  assign bytes_o = legal ? ({{SLOT_SHIFT{1'b0}}, code_i} << SLOT_SHIFT)
                         : '0;
endmodule

// File: rtl/exc_base_reg.sv
module exc_base_reg
  import exc_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              bev_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              reject_o,
  output logic              wr_accept_o,
  output logic              wr_ignore_o
);
  logic [BASE_W-1:0] field_q;
  logic              reject_q;

  assign wr_accept_o = wr_i && bev_i;
  assign wr_ignore_o = wr_i && !bev_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q  <= '0;
      reject_q <= 1'b0;
    end else begin
      if (wr_accept_o) field_q <= wdata_i[BASE_HI:BASE_LO];
      reject_q <= wr_ignore_o;
    end
  end

  assign base_o   = base_image(field_q);
  assign reject_o = reject_q;
endmodule

// File: rtl/exc_addr_calc.sv
module exc_addr_calc
  import exc_vec_pkg::*;
#(
  parameter int VEC_W = 6,
  parameter int SPC_W = 5
) (
  input  exc_cls_e                    cls_i,
  input  logic [VEC_W-1:0]            vec_i,
  input  logic                        bev_i,
  input  logic                        iv_i,
  input  logic [ADDR_W-1:0]           base_i,
  input  logic [SPC_W+SLOT_SHIFT-1:0] bytes_i,
  output logic [ADDR_W-1:0]           addr_o
);
  localparam int PROD_W = VEC_W + SPC_W + SLOT_SHIFT;

  logic              is_fixed;
  logic              use_slot;
  logic [PROD_W-1:0] slot_ofs;
  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] slot_ext;

  assign is_fixed = (cls_i == CLS_FIXED);
  assign use_slot = (cls_i == CLS_INTR) && iv_i && !bev_i;
  assign slot_ofs = PROD_W'(vec_i) * PROD_W'(bytes_i);
  assign slot_ext = use_slot ? ADDR_W'(slot_ofs) : '0;
  assign base_sel = bev_i ? BOOT_BASE : base_i;

  always_comb begin
    if (is_fixed) addr_o = BOOT_BASE;
    else          addr_o = base_sel + fixed_offset(cls_i, iv_i) + slot_ext;
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_vec_pkg::*;
#(
  parameter int VEC_W = 6,
  parameter int SPC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [1:0]        class_i,
  input  logic [VEC_W-1:0]  vec_num_i,
  input  logic              bev_i,
  input  logic              iv_i,
  input  logic [SPC_W-1:0]  spacing_i,
  input  logic              base_wr_i,
  input  logic [31:0]       base_wdata_i,
  output logic [31:0]       base_o,
  output logic [31:0]       addr_o,
  output logic              addr_valid_o,
  output logic              wr_reject_o,
  output logic              cfg_bad_o
);
  localparam int BYTES_W = SPC_W + SLOT_SHIFT;

  logic [BYTES_W-1:0] spc_bytes;
  logic [ADDR_W-1:0]  next_addr;
  logic [ADDR_W-1:0]  base_val;
  logic               wr_accept;
  logic               wr_ignore;
  logic [ADDR_W-1:0]  addr_q;
  logic               valid_q;

  exc_spacing_dec #(.SPC_W(SPC_W)) u_spc (
    .code_i (spacing_i),
    .bytes_o(spc_bytes),
    .bad_o  (cfg_bad_o)
  );

  exc_base_reg u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (base_wr_i),
    .wdata_i    (base_wdata_i),
    .bev_i      (bev_i),
    .base_o     (base_val),
    .reject_o   (wr_reject_o),
    .wr_accept_o(wr_accept),
    .wr_ignore_o(wr_ignore)
  );

  exc_addr_calc #(.VEC_W(VEC_W), .SPC_W(SPC_W)) u_calc (
    .cls_i  (exc_cls_e'(class_i)),
    .vec_i  (vec_num_i),
    .bev_i  (bev_i),
    .iv_i   (iv_i),
    .base_i (base_val),
    .bytes_i(spc_bytes),
    .addr_o (next_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take_i;
      if (take_i) addr_q <= next_addr;
    end
  end

  assign base_o       = base_val;
  assign addr_o       = addr_q;
  assign addr_valid_o = valid_q;
endmodule

// File: rtl/exc_vector_gen_sva.sv
module exc_vector_gen_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        take_i,
  input logic [1:0]  class_i,
  input logic        bev_i,
  input logic        iv_i,
  input logic        base_wr_i,
  input logic [31:0] base_wdata_i,
  input logic [31:0] base_o,
  input logic [31:0] addr_o,
  input logic        addr_valid_o,
  input logic        wr_reject_o,
  input logic [31:0] next_addr,
  input logic        wr_accept,
  input logic        wr_ignore
);
  // R10: valid pulse tracks the strobe one cycle later
  a_r10_valid_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> addr_valid_o);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> !addr_valid_o);
  a_r10_addr_captured: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> addr_o == $past(next_addr));

  // R2: fixed-entry class
  a_r2_fixed_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && class_i == 2'd0) |=> addr_o == 32'hBFC0_0000);

  // R3: boot mode keeps non-fixed vectors in the boot page
  a_r3_boot_page: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && bev_i && class_i != 2'd0) |=> addr_o[31:12] == 20'hBFC00);

  // R5: general exceptions in boot mode
  a_r5_general_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && bev_i && class_i[1]) |=> addr_o == 32'hBFC0_0180);

  // R8: accepted write lands in the writable field
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> base_o[29:12] == $past(base_wdata_i[29:12]));

  // R9: ignored write keeps the base and raises the flag
  a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignore |=> (wr_reject_o && $stable(base_o)));
  a_r9_no_false_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_wr_i && !bev_i) |=> !wr_reject_o);
endmodule

bind exc_vector_gen exc_vector_gen_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .take_i      (take_i),
  .class_i     (class_i),
  .bev_i       (bev_i),
  .iv_i        (iv_i),
  .base_wr_i   (base_wr_i),
  .base_wdata_i(base_wdata_i),
  .base_o      (base_o),
  .addr_o      (addr_o),
  .addr_valid_o(addr_valid_o),
  .wr_reject_o (wr_reject_o),
  .next_addr   (next_addr),
  .wr_accept   (wr_accept),
  .wr_ignore   (wr_ignore)
);

// File: tb/exc_vector_gen_tb_top.sv
`timescale 1ns/1ps
module exc_vector_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 1'b0;
  logic [1:0]  class_i = '0;
  logic [5:0]  vec_num_i = '0;
  logic        bev_i = 1'b1;
  logic        iv_i = 1'b0;
  logic [4:0]  spacing_i = '0;
  logic        base_wr_i = 1'b0;
  logic [31:0] base_wdata_i = '0;
  logic [31:0] base_o;
  logic [31:0] addr_o;
  logic        addr_valid_o;
  logic        wr_reject_o;
  logic        cfg_bad_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_base = 32'h8000_0000;

  always #2 clk = ~clk;

  exc_vector_gen dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .class_i(class_i),
    .vec_num_i(vec_num_i), .bev_i(bev_i), .iv_i(iv_i), .spacing_i(spacing_i),
    .base_wr_i(base_wr_i), .base_wdata_i(base_wdata_i), .base_o(base_o),
    .addr_o(addr_o), .addr_valid_o(addr_valid_o), .wr_reject_o(wr_reject_o),
    .cfg_bad_o(cfg_bad_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] spacing_model(input logic [4:0] s);
    if (s inside {5'd1, 5'd2, 5'd4, 5'd8, 5'd16}) return 32'(s) * 32;
    return 32'd0;
  endfunction

  function automatic logic [31:0] expect_addr(input logic [1:0] c, input logic [5:0] v,
                                              input logic b, input logic i, input logic [4:0] s);
    logic [31:0] base, ofs, slot;
    if (c == 2'd0) return 32'hBFC0_0000;
    base = b ? 32'hBFC0_0000 : model_base;
    ofs  = (c == 2'd1 && i) ? 32'h200 : 32'h180;
    slot = (c == 2'd1 && i && !b) ? 32'(v) * spacing_model(s) : 32'd0;
    return base + ofs + slot;
  endfunction

  // one take: R10 timing, R2..R7 address values
  task automatic do_take(input logic [1:0] c, input logic [5:0] v,
                         input logic b, input logic i, input logic [4:0] s);
    string tag;
    @(negedge clk);
    class_i = c; vec_num_i = v; bev_i = b; iv_i = i; spacing_i = s; take_i = 1'b1;
    @(negedge clk);
    take_i = 1'b0;
    if (c == 2'd0) tag = "R2";
    else if (b) tag = "R3";
    else if (c == 2'd1 && i) tag = "R6";
    else tag = "R4";
    check(tag, addr_o, expect_addr(c, v, b, i, s));
    check("R10 valid", {31'd0, addr_valid_o}, 32'd1);
    check("R7 cfg flag", {31'd0, cfg_bad_o}, {31'd0, spacing_model(s) == 0 && s != 0});
    @(negedge clk);
    check("R10 pulse end", {31'd0, addr_valid_o}, 32'd0);
  endtask

  task automatic sweep();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 2; i++)
        for (int c = 0; c < 4; c++)
          for (int v = 0; v < 64; v++)
            for (int s = 0; s < ((c == 1) ? 32 : 2); s++)
              do_take(2'(c), 6'(v), 1'(b), 1'(i), 5'(s));
  endtask

  task automatic write_base(input logic [31:0] d, input logic b);
    @(negedge clk);
    base_wr_i = 1'b1; base_wdata_i = d; bev_i = b;
    @(negedge clk);
    base_wr_i = 1'b0;
    if (b) begin
      model_base = {2'b10, d[29:12], 12'h000};
      check("R8 base load", base_o, model_base);
      check("R9 no reject on accept", {31'd0, wr_reject_o}, 32'd0);
    end else begin
      check("R9 base kept", base_o, model_base);
      check("R9 reject flag", {31'd0, wr_reject_o}, 32'd1);
    end
    @(negedge clk);
    check("R9 flag one cycle", {31'd0, wr_reject_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 base reset", base_o, 32'h8000_0000);
    check("R1 valid reset", {31'd0, addr_valid_o}, 32'd0);
    check("R1 reject reset", {31'd0, wr_reject_o}, 32'd0);

    write_base(32'h9FC0_1000, 1'b1);
    do_take(2'd1, 6'd8, 1'b0, 1'b1, 5'd1);
    check("R6 worked example", addr_o, 32'h9FC0_1300);
    write_base(32'h1234_5678, 1'b0);
    check("R9 address unaffected", expect_addr(2'd2, 6'd0, 1'b0, 1'b0, 5'd0), 32'h9FC0_1180);
    do_take(2'd2, 6'd0, 1'b0, 1'b0, 5'd0);
    sweep();

    write_base(32'hFFFF_FFFF, 1'b1);
    check("R8 fixed bits", base_o, 32'hBFFF_F000);
    sweep();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule